// File: doc/BRIEF.md
# Paired-Channel PWM Timer

This block makes a pulse-width-modulated output from two down-counting timer channels that work as a pair. The leader channel runs as a free-running interval timer. Each time it completes, it raises an event that marks the start of a PWM period and reloads it from the period register. The follower channel is a one-shot counter. Every leader event retriggers it with the duty register, and it holds the output active until it counts out.

Software writes the period and duty registers at any time. The counters copy them only at a leader event, so a new pair of values always starts on a period boundary. The width of an active interval follows from the duty value. A duty of zero keeps the pin inactive for the whole period. A duty at or above the period length keeps the pin active without a gap. All counting is gated by a count-clock enable, so a prescaler outside the block sets the time base.

Top module: `pwm_pair_timer`

## Requirements
- R1: After a synchronous reset, both interrupt outputs are low, the pin sits at its inactive level (`pwm_out` equals `act_low`), and the period and duty registers hold 0.
- R2: While running, `master_irq` pulses once every (P+1) count ticks, where P is the period value latched at the previous leader event. With `cnt_en` held high, this is every P+1 clocks.
- R3: For a duty value D with 1 <= D <= P, the pin is active for exactly D clocks in each period, with `cnt_en` held high.
- R4: A start pulse that is not accompanied by stop gives `master_irq` high in the next clock. It also loads both counters from the registers, which restarts a running timer.
- R5: The pin becomes active in the clock after the `master_irq` pulse, unless D is 0.
- R6: For 1 <= D <= P, `slave_irq` pulses D clocks after `master_irq`, in the last active clock. The pin is inactive in the following clock.
- R7: A stop pulse drives the pin to its inactive level in the next clock. Both counters freeze, and no interrupt is raised until the next start.
- R8: With D = 0, the pin stays inactive for the whole period, and `slave_irq` pulses in the same clock as `master_irq`.
- R9: With D >= P+1, the pin stays active in every clock of every period once it has first become active. No `slave_irq` pulse is raised.
- R10: A write to the period or duty register has no effect on the period in progress. It takes effect from the next leader event.
- R11: `act_low` = 0 makes the active level high. `act_low` = 1 makes it low and the idle level high.
- R12: The counters advance only in clocks where `cnt_en` is high. With `cnt_en` high in every second clock, leader events come every 2(P+1) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count-clock enable; one tick per high cycle |
| start_trig | input | 1 | Start pulse; begins or restarts the pair |
| stop_trig | input | 1 | Stop pulse; freezes counters, pin inactive |
| period_wr | input | 1 | Write strobe for the period register |
| period_wdata | input | CNT_W | Period value P |
| duty_wr | input | 1 | Write strobe for the duty register |
| duty_wdata | input | CNT_W | Duty value D |
| act_low | input | 1 | Active level select (1 = active low) |
| pwm_out | output | 1 | PWM pin |
| master_irq | output | 1 | Leader channel completion pulse |
| slave_irq | output | 1 | Follower channel completion pulse |

## Verification
The checker holds several relations in every cycle. A start pulse must be followed by a leader interrupt. A stop pulse must be followed by an idle pin and silent interrupt lines. Every rising edge of the active level must come right after a leader interrupt. Every falling edge must come right after a follower interrupt or a stop. Only the bench scenarios can show the numeric claims: period length, active width, the 0% and 100% clamps, when buffered writes take effect, and stretching under a gated count enable. The bench measures whole periods against formulas for these.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
   // index of each data register inside the bank
   typedef enum logic [0:0] {
      SEL_PERIOD = 1'b0,
      SEL_DUTY   = 1'b1
   } dreg_sel_e;

   localparam int unsigned NUM_DREGS = 2;
   localparam int unsigned MIN_CNT_W = 2;
   localparam int unsigned MAX_CNT_W = 32;
endpackage

// File: rtl/pwm_data_bank.sv
module pwm_data_bank
   import pwm_pair_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned N     = NUM_DREGS
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [N-1:0]            wr_en,
   input  logic [N-1:0][CNT_W-1:0] wr_data,
   output logic [N-1:0][CNT_W-1:0] rd_data
);
   // one holding register per data word; counters sample them only at events
   for (genvar i = 0; i < N; i++) begin : g_reg
      logic [CNT_W-1:0] hold_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            hold_q <= '0;
         end else if (wr_en[i]) begin
            hold_q <= wr_data[i];
         end
      end
      assign rd_data[i] = hold_q;
   end
endmodule

// File: rtl/pwm_master_chan.sv
module pwm_master_chan #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             start,
   input  logic             stop,
   input  logic [CNT_W-1:0] reload,
   output logic             evt,
   output logic             irq
);
   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = run_q && tick && (cnt_q == '0);
   assign evt  = !stop && (start || wrap);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         irq   <= 1'b0;
      end else begin
         irq <= evt;
         if (stop) begin
            run_q <= 1'b0;
         end else if (evt) begin
            run_q <= 1'b1;
            cnt_q <= reload;
         end else if (run_q && tick) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/pwm_slave_chan.sv
module pwm_slave_chan #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             trig,
   input  logic             stop,
   input  logic [CNT_W-1:0] reload,
   output logic             busy,
   output logic             irq
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         busy  <= 1'b0;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (stop) begin
            busy <= 1'b0;
         end else if (trig) begin
            // a retrigger outranks a count-out in the same cycle: 100% clamp
            cnt_q <= reload;
            busy  <= (reload != '0);
            irq   <= (reload == '0);
         end else if (busy && tick) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == LAST) begin
               busy <= 1'b0;
               irq  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage (
   input  logic clk,
   input  logic rst,
   input  logic busy,
   input  logic stop,
   input  logic act_low,
   output logic active,
   output logic pin
);
   // active level trails the follower's busy flag by one clock
   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
      end else begin
         active <= busy && !stop;
      end
   end

   assign pin = active ^ act_low;
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
   import pwm_pair_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cnt_en,
   input  logic             start_trig,
   input  logic             stop_trig,
   input  logic             period_wr,
   input  logic [CNT_W-1:0] period_wdata,
   input  logic             duty_wr,
   input  logic [CNT_W-1:0] duty_wdata,
   input  logic             act_low,
   output logic             pwm_out,
   output logic             master_irq,
   output logic             slave_irq
);
   if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_width
      $error("pwm_pair_timer: CNT_W out of range");
   end

   logic [NUM_DREGS-1:0]            bank_wr;
   logic [NUM_DREGS-1:0][CNT_W-1:0] bank_wdata;
   logic [NUM_DREGS-1:0][CNT_W-1:0] bank_rd;
   logic                            lead_evt;
   logic                            fol_busy;
   logic                            out_act;

   always_comb begin
      bank_wr    = '0;
      bank_wdata = '0;
      bank_wr[SEL_PERIOD]    = period_wr;
      bank_wr[SEL_DUTY]      = duty_wr;
      bank_wdata[SEL_PERIOD] = period_wdata;
      bank_wdata[SEL_DUTY]   = duty_wdata;
   end

   pwm_data_bank #(.CNT_W(CNT_W), .N(NUM_DREGS)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bank_wr),
      .wr_data (bank_wdata),
      .rd_data (bank_rd)
   );

   pwm_master_chan #(.CNT_W(CNT_W)) u_lead (
      .clk    (clk),
      .rst    (rst),
      .tick   (cnt_en),
      .start  (start_trig),
      .stop   (stop_trig),
      .reload (bank_rd[SEL_PERIOD]),
      .evt    (lead_evt),
      .irq    (master_irq)
   );

   pwm_slave_chan #(.CNT_W(CNT_W)) u_fol (
      .clk    (clk),
      .rst    (rst),
      .tick   (cnt_en),
      .trig   (lead_evt),
      .stop   (stop_trig),
      .reload (bank_rd[SEL_DUTY]),
      .busy   (fol_busy),
      .irq    (slave_irq)
   );

   pwm_out_stage u_out (
      .clk     (clk),
      .rst     (rst),
      .busy    (fol_busy),
      .stop    (stop_trig),
      .act_low (act_low),
      .active  (out_act),
      .pin     (pwm_out)
   );
endmodule

// File: rtl/pwm_pair_timer_chk.sv
module pwm_pair_timer_chk (
   input logic clk,
   input logic rst,
   input logic start_trig,
   input logic stop_trig,
   input logic act_low,
   input logic pwm_out,
   input logic master_irq,
   input logic slave_irq,
   input logic out_act
);
   p_start_irq_r4: assert property (@(posedge clk) disable iff (rst)
      (start_trig && !stop_trig) |=> master_irq);

   p_stop_idle_r7: assert property (@(posedge clk) disable iff (rst)
      stop_trig |=> (pwm_out == act_low));

   p_stop_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      stop_trig |=> (!master_irq && !slave_irq));

   p_rise_after_lead_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(out_act) |-> $past(master_irq));

   p_fall_after_fol_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(out_act) |-> ($past(slave_irq) || $past(stop_trig)));
endmodule

bind pwm_pair_timer pwm_pair_timer_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .start_trig (start_trig),
   .stop_trig  (stop_trig),
   .act_low    (act_low),
   .pwm_out    (pwm_out),
   .master_irq (master_irq),
   .slave_irq  (slave_irq),
   .out_act    (out_act)
);

// File: tb/pwm_pair_timer_test.sv
`timescale 1ns/1ps
module pwm_pair_timer_test;
   localparam int unsigned W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         cnt_en = 1'b1;
   logic         start_trig = 1'b0;
   logic         stop_trig = 1'b0;
   logic         period_wr = 1'b0;
   logic [W-1:0] period_wdata = '0;
   logic         duty_wr = 1'b0;
   logic [W-1:0] duty_wdata = '0;
   logic         act_low = 1'b0;
   logic         pwm_out;
   logic         master_irq;
   logic         slave_irq;

   int  errors = 0;
   int  checks = 0;
   int  cyc = 0;
   bit  alt_en = 1'b0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_pair_timer #(.CNT_W(W)) uut (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .start_trig(start_trig),
      .stop_trig(stop_trig), .period_wr(period_wr), .period_wdata(period_wdata),
      .duty_wr(duty_wr), .duty_wdata(duty_wdata), .act_low(act_low),
      .pwm_out(pwm_out), .master_irq(master_irq), .slave_irq(slave_irq)
   );

   function automatic int exp_high(int p, int d);
      return (d >= p + 1) ? p + 1 : d;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // advance one clock; sample and drive 1 ns after the edge
   task automatic cycle();
      @(posedge clk);
      #1;
      cyc++;
      if (alt_en) cnt_en = ~cnt_en;
   endtask

   function automatic bit active();
      return pwm_out ^ act_low;
   endfunction

   task automatic write_regs(int p, int d);
      period_wr = 1'b1; period_wdata = W'(p);
      duty_wr = 1'b1;   duty_wdata = W'(d);
      cycle();
      period_wr = 1'b0; duty_wr = 1'b0;
   endtask

   task automatic restart();
      stop_trig = 1'b1; cycle(); stop_trig = 1'b0;
      start_trig = 1'b1; cycle(); start_trig = 1'b0;
   endtask

   // from a sample showing master_irq, run to the next one
   task automatic run_period(bit do_wr, int wp, int wd,
                             output int n, output int hi, output int sidx,
                             output int first_act);
      n = 0; hi = 0; sidx = -1; first_act = -1;
      if (do_wr) begin
         period_wr = 1'b1; period_wdata = W'(wp);
         duty_wr = 1'b1;   duty_wdata = W'(wd);
      end
      do begin
         cycle();
         period_wr = 1'b0; duty_wr = 1'b0;
         n++;
         if (active()) begin
            hi++;
            if (first_act < 0) first_act = n;
         end
         if (slave_irq && sidx < 0 && !master_irq) sidx = n;
      end while (!master_irq && n < 5000);
   endtask

   task automatic measure(int p, int d, string tag);
      int n, hi, sidx, fa;
      write_regs(p, d);
      restart();
      chk(master_irq == 1'b1, {tag, " R4 irq after start"}, master_irq, 1);
      chk(slave_irq == (d == 0), {tag, " R8 slave irq at event"}, slave_irq, d == 0);
      run_period(1'b0, 0, 0, n, hi, sidx, fa);
      chk(n == p + 1, {tag, " R2 period"}, n, p + 1);
      chk(hi == exp_high(p, d), {tag, " R3 active width"}, hi, exp_high(p, d));
      if (d >= 1 && d <= p) chk(sidx == d, {tag, " R6 slave irq position"}, sidx, d);
      if (d >= p + 1) chk(sidx == -1, {tag, " R9 no slave irq"}, sidx, -1);
      if (d != 0) chk(fa == 1, {tag, " R5 first active clock"}, fa, 1);
   endtask

   initial begin
      int n, hi, sidx, fa;
      int seed;
      seed = $urandom(32'h00C0FFEE);
      repeat (4) cycle();
      rst = 1'b0;
      cycle();
      // R1 reset state
      chk(pwm_out == 1'b0, "R1 pin idle", pwm_out, 0);
      chk(!master_irq && !slave_irq, "R1 irqs low", master_irq + slave_irq, 0);
      act_low = 1'b1; #0.1;
      chk(pwm_out == 1'b1, "R11 idle level high when active low", pwm_out, 1);
      act_low = 1'b0;

      // registers cleared: start with no writes gives P=0, D=0
      start_trig = 1'b1; cycle(); start_trig = 1'b0;
      run_period(1'b0, 0, 0, n, hi, sidx, fa);
      chk(n == 1 && hi == 0, "R1 cleared registers P=0 D=0", n * 10 + hi, 10);

      measure(9, 3, "dir9_3");
      measure(9, 0, "dir_zero");
      measure(6, 7, "dir_full_eq");
      measure(6, 13, "dir_full_gt");
      measure(1, 1, "dir_small");
      measure(300, 150, "dir_large");

      // R9 continuous across two periods
      write_regs(5, 6);
      restart();
      run_period(1'b0, 0, 0, n, hi, sidx, fa);
      run_period(1'b0, 0, 0, n, hi, sidx, fa);
      chk(hi == 6 && n == 6, "R9 second period fully active", hi, 6);

      // R10 buffered write
      write_regs(8, 2);
      restart();
      run_period(1'b1, 14, 5, n, hi, sidx, fa);
      chk(n == 9, "R10 period unchanged after write", n, 9);
      chk(hi == 2, "R10 duty unchanged after write", hi, 2);
      run_period(1'b0, 0, 0, n, hi, sidx, fa);
      chk(n == 15, "R10 new period at next event", n, 15);
      chk(hi == 5, "R10 new duty at next event", hi, 5);

      // R11 active low
      act_low = 1'b1;
      write_regs(10, 4);
      restart();
      run_period(1'b0, 0, 0, n, hi, sidx, fa);
      chk(hi == 4, "R11 low time equals duty", hi, 4);
      act_low = 1'b0;

      // R12 alternate enable
      write_regs(7, 3);
      restart();
      alt_en = 1'b1;
      run_period(1'b0, 0, 0, n, hi, sidx, fa);
      run_period(1'b0, 0, 0, n, hi, sidx, fa);
      chk(n == 16, "R12 gated period", n, 16);
      alt_en = 1'b0; cnt_en = 1'b1;

      // R7 stop
      write_regs(4, 3);
      restart();
      cycle();
      stop_trig = 1'b1; cycle(); stop_trig = 1'b0;
      chk(active() == 1'b0, "R7 pin inactive after stop", active(), 0);
      begin
         int seen = 0;
         for (int k = 0; k < 20; k++) begin
            cycle();
            if (master_irq || slave_irq || active()) seen++;
         end
         chk(seen == 0, "R7 silent while stopped", seen, 0);
      end

      // random mix
      for (int r = 0; r < 14; r++) begin
         int p, d;
         p = int'($urandom_range(0, 60));
         d = int'($urandom_range(0, p + 6));
         measure(p, d, $sformatf("rand%0d", r));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule